// File: doc/BRIEF.md
# Multicycle Processor Datapath

This block is the shared-resource datapath of a 32-bit multicycle processor. One ALU does every arithmetic step: it increments the PC, forms the branch target, computes load and store addresses, and runs the register operations. One word-organised memory supplies both instructions and data. The datapath holds three registers: the PC, the instruction register and the branch-target register. It also has a 32-entry register file with two read ports and one write port, and an immediate extender. The datapath makes no decisions. An external sequencer drives every multiplexer select and write enable, one cycle at a time. The datapath returns the opcode and function fields of the instruction and the ALU zero flag to that sequencer.

No register sits on the register-file read buses, on the ALU result or on the memory read data. A value that is computed in one cycle and consumed in a later one survives because the sequencer keeps the instruction register, the selects and the ALU mode unchanged across those cycles. A word-wide load port fills the memory before and between instruction steps, so that a program and its data can be placed there.

Top module: `mcd_datapath`

## Requirements
- R1: While `rst` is high at a clock edge, the PC and the instruction register clear to zero, so `pc_o` and `ir_o` read 0 after that edge.
- R2: With `ir_wr=1` the instruction register captures the memory word at the PC when `addr_sel=0`. With `pc_wr=1`, `a_sel=0`, `b_sel=00`, `alu_mode=00` and `pc_sel=00`, the PC becomes PC+4 in that same edge. `opcode_o` is instruction bits [31:26] and `funct_o` is bits [5:0].
- R3: The ALU A operand is the PC when `a_sel=0` and register rs (bits [25:21]) when `a_sel=1`. The B operand is chosen by `b_sel`: 00 gives 4, 01 gives register rt (bits [20:16]), 10 gives the extended immediate shifted left by 2, and 11 gives the extended immediate. `alu_mode` 00 adds, 01 subtracts, 10 ORs, and 11 lets funct choose the operation: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x2A signed set-less-than. Any other funct gives 0. `zero_o` is high exactly when the ALU result is 0.
- R4: The 16-bit immediate (bits [15:0]) is sign-extended when `ext_signed=1` and zero-extended when `ext_signed=0`.
- R5: With `br_wr=1` the target register captures the ALU result. `pc_sel=01` loads the target register into the PC. The PC is written when `pc_wr=1`, or when `pc_wr_cond=1` and the zero flag is set. Otherwise the PC holds.
- R6: With `reg_wr=1` the register at rd (bits [15:11]) is written when `dst_sel=1`, and the register at rt when `dst_sel=0`. The data written is the memory read word when `wb_sel=1` and the ALU result when `wb_sel=0`. Register 0 always reads 0, and writes to it have no effect.
- R7: The memory read address is the PC when `addr_sel=0` and the ALU result when `addr_sel=1`. With `mem_wr=1` the rt register value is stored at the ALU-result address. Byte-address bits [1:0] are ignored, so an address selects word address[MEM_AW+1:2].
- R8: While `ir_wr=0` the instruction register keeps its value.
- R9: `pc_sel=10` (and 11) loads the PC with the PC's top four bits, then instruction bits [25:0], then two zero bits.
- R10: With `load_we=1`, `load_data` is written to the memory word `load_addr`. This takes priority over `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_wr | input | 1 | Unconditional PC write |
| pc_wr_cond | input | 1 | PC write when the zero flag is set |
| ir_wr | input | 1 | Instruction register write |
| mem_wr | input | 1 | Data store enable |
| reg_wr | input | 1 | Register file write |
| br_wr | input | 1 | Branch-target register write |
| addr_sel | input | 1 | Memory read address: 0 PC, 1 ALU result |
| dst_sel | input | 1 | Destination register: 0 rt, 1 rd |
| wb_sel | input | 1 | Write-back source: 0 ALU, 1 memory |
| ext_signed | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| a_sel | input | 1 | ALU A operand: 0 PC, 1 rs |
| b_sel | input | 2 | ALU B operand select |
| pc_sel | input | 2 | Next-PC source select |
| alu_mode | input | 2 | ALU operation class |
| load_we | input | 1 | Load port write enable |
| load_addr | input | MEM_AW | Load port word address |
| load_data | input | XLEN | Load port data |
| opcode_o | output | 6 | Instruction opcode field |
| funct_o | output | 6 | Instruction function field |
| zero_o | output | 1 | ALU zero flag |
| pc_o | output | XLEN | Current PC |
| ir_o | output | XLEN | Instruction register |
| alu_o | output | XLEN | ALU result |
| mem_o | output | XLEN | Memory read word |

## Verification
The bench keeps the default parameters: a 32-bit word and an 8-bit word address, which gives a 256-word memory. With a memory that small, randomly taken branches and jumps wrap the instruction stream onto the words that loads and stores use. This exercises the shared instruction/data space and the way address bits above the memory size are ignored. The full 32-entry register file lets random R-type, OR-immediate, load, store, branch and jump sequences reach both register 0 and the top register.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  typedef enum logic [1:0] {
    MODE_ADD   = 2'b00,
    MODE_SUB   = 2'b01,
    MODE_OR    = 2'b10,
    MODE_FUNCT = 2'b11
  } alu_mode_e;

  typedef enum logic [1:0] {
    BSEL_FOUR   = 2'b00,
    BSEL_RT     = 2'b01,
    BSEL_IMM_SH = 2'b10,
    BSEL_IMM    = 2'b11
  } bsel_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  localparam int IMM_W  = 16;
  localparam int JIDX_W = 26;
endpackage

// File: rtl/mcd_alu.sv
module mcd_alu import mcd_pkg::*; #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   mode,
  input  logic [5:0]   funct,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] sum, diff, lt;

  assign sum  = a + b;
  assign diff = a - b;
  assign lt   = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};

  always_comb begin
    unique case (alu_mode_e'(mode))
      MODE_ADD: y = sum;
      MODE_SUB: y = diff;
      MODE_OR:  y = a | b;
      default: begin
        case (funct)
          FN_ADD:  y = sum;
          FN_SUB:  y = diff;
          FN_AND:  y = a & b;
          FN_OR:   y = a | b;
          FN_SLT:  y = lt;
          default: y = '0;
        endcase
      end
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] waddr,
  input  logic [W-1:0]            wdata,
  input  logic [$clog2(NREG)-1:0] raddr_a,
  input  logic [$clog2(NREG)-1:0] raddr_b,
  output logic [W-1:0]            rdata_a,
  output logic [W-1:0]            rdata_b
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  assign rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
  assign rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
endmodule

// File: rtl/mcd_memory.sv
module mcd_memory #(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath import mcd_pkg::*; #(
  parameter int XLEN   = 32,
  parameter int MEM_AW = 8,
  parameter int NREG   = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pc_wr,
  input  logic              pc_wr_cond,
  input  logic              ir_wr,
  input  logic              mem_wr,
  input  logic              reg_wr,
  input  logic              br_wr,
  input  logic              addr_sel,
  input  logic              dst_sel,
  input  logic              wb_sel,
  input  logic              ext_signed,
  input  logic              a_sel,
  input  logic [1:0]        b_sel,
  input  logic [1:0]        pc_sel,
  input  logic [1:0]        alu_mode,
  input  logic              load_we,
  input  logic [MEM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  output logic [5:0]        opcode_o,
  output logic [5:0]        funct_o,
  output logic              zero_o,
  output logic [XLEN-1:0]   pc_o,
  output logic [XLEN-1:0]   ir_o,
  output logic [XLEN-1:0]   alu_o,
  output logic [XLEN-1:0]   mem_o
);
  localparam int RA_W   = $clog2(NREG);
  localparam int WLSB   = 2;
  localparam int WMSB   = MEM_AW + WLSB - 1;
  localparam int PC_TOP = XLEN - JIDX_W - WLSB;

  logic [XLEN-1:0] pc_q, ir_q, tgt_q;
  logic [XLEN-1:0] bus_a, bus_b;
  logic [XLEN-1:0] ext_imm, alu_a, alu_b, alu_y;
  logic [XLEN-1:0] mem_rdata, wb_data, pc_next, jump_pc;
  logic            alu_zero, pc_load;
  logic [4:0]      f_rs, f_rt, f_rd, wb_reg;
  logic [IMM_W-1:0] f_imm;

  assign f_rs  = ir_q[25:21];
  assign f_rt  = ir_q[20:16];
  assign f_rd  = ir_q[15:11];
  assign f_imm = ir_q[IMM_W-1:0];

  // immediate extender
  assign ext_imm = ext_signed ? {{(XLEN-IMM_W){f_imm[IMM_W-1]}}, f_imm}
                              : {{(XLEN-IMM_W){1'b0}}, f_imm};

  mcd_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .we     (reg_wr),
    .waddr  (wb_reg[RA_W-1:0]),
    .wdata  (wb_data),
    .raddr_a(f_rs[RA_W-1:0]),
    .raddr_b(f_rt[RA_W-1:0]),
    .rdata_a(bus_a),
    .rdata_b(bus_b)
  );

  // operand selection
  assign alu_a = a_sel ? bus_a : pc_q;
  always_comb begin
    unique case (bsel_e'(b_sel))
      BSEL_FOUR:   alu_b = XLEN'(4);
      BSEL_RT:     alu_b = bus_b;
      BSEL_IMM_SH: alu_b = {ext_imm[XLEN-3:0], 2'b00};
      default:     alu_b = ext_imm;
    endcase
  end

  mcd_alu #(.W(XLEN)) u_alu (
    .a    (alu_a),
    .b    (alu_b),
    .mode (alu_mode),
    .funct(ir_q[5:0]),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // unified memory, load port has priority
  mcd_memory #(.W(XLEN), .AW(MEM_AW)) u_mem (
    .clk  (clk),
    .we   (load_we | mem_wr),
    .waddr(load_we ? load_addr : alu_y[WMSB:WLSB]),
    .wdata(load_we ? load_data : bus_b),
    .raddr(addr_sel ? alu_y[WMSB:WLSB] : pc_q[WMSB:WLSB]),
    .rdata(mem_rdata)
  );

  // write-back
  assign wb_reg  = dst_sel ? f_rd : f_rt;
  assign wb_data = wb_sel ? mem_rdata : alu_y;

  // next PC
  assign jump_pc = {pc_q[XLEN-1 -: PC_TOP], ir_q[JIDX_W-1:0], 2'b00};
  always_comb begin
    unique case (pc_sel)
      2'b00:   pc_next = alu_y;
      2'b01:   pc_next = tgt_q;
      default: pc_next = jump_pc;
    endcase
  end
  assign pc_load = pc_wr | (pc_wr_cond & alu_zero);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      ir_q  <= '0;
      tgt_q <= '0;
    end else begin
      if (pc_load) pc_q  <= pc_next;
      if (ir_wr)   ir_q  <= mem_rdata;
      if (br_wr)   tgt_q <= alu_y;
    end
  end

  assign opcode_o = ir_q[31:26];
  assign funct_o  = ir_q[5:0];
  assign zero_o   = alu_zero;
  assign pc_o     = pc_q;
  assign ir_o     = ir_q;
  assign alu_o    = alu_y;
  assign mem_o    = mem_rdata;

  // checks
  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> (pc_q == '0 && ir_q == '0));

  assert_pc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(pc_wr || (pc_wr_cond && alu_zero)) |=> $stable(pc_q));

  assert_target_cap_R5: assert property (@(posedge clk) disable iff (rst)
    br_wr |=> (tgt_q == $past(alu_y)));

  assert_branch_take_R5: assert property (@(posedge clk) disable iff (rst)
    (pc_wr_cond && alu_zero && !pc_wr && pc_sel == 2'b01) |=> (pc_q == $past(tgt_q)));

  assert_ir_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !ir_wr |=> $stable(ir_q));

  assert_r0_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (f_rs == 5'd0) |-> (bus_a == '0));

  assert_sub_equal_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (alu_mode == 2'b01 && alu_a == alu_b) |-> alu_zero);
endmodule

// File: tb/mcd_datapath_bench.sv
module mcd_datapath_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int MEM_AW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, br_wr;
  logic addr_sel, dst_sel, wb_sel, ext_signed, a_sel;
  logic [1:0] b_sel, pc_sel, alu_mode;
  logic load_we;
  logic [MEM_AW-1:0] load_addr;
  logic [XLEN-1:0] load_data;
  logic [5:0] opcode_o, funct_o;
  logic zero_o;
  logic [XLEN-1:0] pc_o, ir_o, alu_o, mem_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] regs_m [32];
  logic [31:0] mem_m [256];
  logic [31:0] pc_m, tgt_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcd_datapath #(.XLEN(XLEN), .MEM_AW(MEM_AW), .NREG(32)) u_mcd_datapath (
    .clk(clk), .rst(rst), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr),
    .mem_wr(mem_wr), .reg_wr(reg_wr), .br_wr(br_wr), .addr_sel(addr_sel),
    .dst_sel(dst_sel), .wb_sel(wb_sel), .ext_signed(ext_signed), .a_sel(a_sel),
    .b_sel(b_sel), .pc_sel(pc_sel), .alu_mode(alu_mode), .load_we(load_we),
    .load_addr(load_addr), .load_data(load_data), .opcode_o(opcode_o),
    .funct_o(funct_o), .zero_o(zero_o), .pc_o(pc_o), .ir_o(ir_o), .alu_o(alu_o),
    .mem_o(mem_o)
  );

  function automatic logic [31:0] sx(logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  function automatic logic [31:0] alu_ref(logic [1:0] m, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    case (m)
      2'b00: return a + b;
      2'b01: return a - b;
      2'b10: return a | b;
      default: case (f)
        6'h20: return a + b;
        6'h22: return a - b;
        6'h24: return a & b;
        6'h25: return a | b;
        6'h2A: return {31'd0, ($signed(a) < $signed(b))};
        default: return 32'd0;
      endcase
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clr();
    {pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, br_wr} = '0;
    {addr_sel, dst_sel, wb_sel, ext_signed, a_sel} = '0;
    b_sel = 2'b00; pc_sel = 2'b00; alu_mode = 2'b00;
    load_we = 1'b0; load_addr = '0; load_data = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // R10 load port
  task automatic load_word(logic [7:0] idx, logic [31:0] d);
    clr();
    load_we = 1'b1; load_addr = idx; load_data = d;
    tick();
    clr();
    mem_m[idx] = d;
  endtask

  task automatic fetch_decode(logic [31:0] instr);
    load_word(pc_m[9:2], instr);
    ir_wr = 1'b1; pc_wr = 1'b1;
    tick();
    clr();
    pc_m = pc_m + 32'd4;
    check("R2 R10 fetched word", ir_o, instr);
    check("R2 pc+4", pc_o, pc_m);
    check("R2 opcode field", {26'd0, opcode_o}, {26'd0, instr[31:26]});
    check("R2 funct field", {26'd0, funct_o}, {26'd0, instr[5:0]});
    br_wr = 1'b1; ext_signed = 1'b1; b_sel = 2'b10;
    tick();
    clr();
    tgt_m = pc_m + {sx(instr[15:0])[29:0], 2'b00};
  endtask

  task automatic do_rtype(logic [5:0] fn, logic [4:0] rs, logic [4:0] rt, logic [4:0] rd);
    logic [31:0] instr, exp;
    instr = {6'd0, rs, rt, rd, 5'd0, fn};
    fetch_decode(instr);
    exp = alu_ref(2'b11, fn, regs_m[rs], regs_m[rt]);
    a_sel = 1'b1; b_sel = 2'b01; alu_mode = 2'b11; dst_sel = 1'b1;
    #1;
    check("R3 funct result", alu_o, exp);
    check("R3 zero flag", {31'd0, zero_o}, {31'd0, exp == 32'd0});
    tick();
    reg_wr = 1'b1;
    tick();
    clr();
    if (rd != 5'd0) regs_m[rd] = exp;
    check("R8 ir held", ir_o, instr);
  endtask

  task automatic do_ori(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    logic [31:0] instr, exp;
    instr = {6'h0D, rs, rt, imm};
    fetch_decode(instr);
    exp = regs_m[rs] | {16'd0, imm};
    a_sel = 1'b1; b_sel = 2'b11; alu_mode = 2'b10;
    #1;
    check("R4 zero-extended or", alu_o, exp);
    tick();
    reg_wr = 1'b1;
    tick();
    clr();
    if (rt != 5'd0) regs_m[rt] = exp;
  endtask

  task automatic do_lw(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    logic [31:0] addr, exp;
    fetch_decode({6'h23, rs, rt, imm});
    addr = regs_m[rs] + sx(imm);
    a_sel = 1'b1; b_sel = 2'b11; ext_signed = 1'b1;
    #1;
    check("R4 sign-extended address", alu_o, addr);
    tick();
    addr_sel = 1'b1;
    #1;
    exp = mem_m[addr[9:2]];
    check("R7 load word", mem_o, exp);
    tick();
    reg_wr = 1'b1; wb_sel = 1'b1;
    tick();
    clr();
    if (rt != 5'd0) regs_m[rt] = exp;
  endtask

  task automatic do_sw(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    logic [31:0] addr;
    fetch_decode({6'h2B, rs, rt, imm});
    addr = regs_m[rs] + sx(imm);
    a_sel = 1'b1; b_sel = 2'b11; ext_signed = 1'b1;
    tick();
    mem_wr = 1'b1;
    tick();
    clr();
    mem_m[addr[9:2]] = regs_m[rt];
  endtask

  task automatic do_beq(logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    bit eq;
    fetch_decode({6'h04, rs, rt, imm});
    eq = (regs_m[rs] == regs_m[rt]);
    a_sel = 1'b1; b_sel = 2'b01; alu_mode = 2'b01; pc_wr_cond = 1'b1; pc_sel = 2'b01;
    #1;
    check("R5 compare zero", {31'd0, zero_o}, {31'd0, eq});
    tick();
    clr();
    if (eq) pc_m = tgt_m;
    check("R5 branch pc", pc_o, pc_m);
  endtask

  task automatic do_jump(logic [25:0] t);
    fetch_decode({6'h02, t});
    pc_wr = 1'b1; pc_sel = 2'b10;
    tick();
    clr();
    pc_m = {pc_m[31:28], t, 2'b00};
    check("R9 jump pc", pc_o, pc_m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    clr();
    for (int i = 0; i < 256; i++) mem_m[i] = 32'd0;
    for (int i = 0; i < 32; i++) regs_m[i] = 32'd0;
    pc_m = 32'd0;
    tgt_m = 32'd0;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset pc", pc_o, 32'd0);
    check("R1 reset ir", ir_o, 32'd0);

    // zero every memory word, then place random data in the upper half
    for (int i = 0; i < 256; i++) load_word(8'(i), (i >= 128) ? $urandom() : 32'd0);

    // seed registers
    for (int r = 1; r < 32; r++) do_ori(5'd0, 5'(r), 16'($urandom()));

    // R6: write to r0 is ignored, r0 reads zero
    do_ori(5'd0, 5'd0, 16'hFFFF);
    do_rtype(6'h25, 5'd0, 5'd0, 5'd9);
    check("R6 r0 stays zero", regs_m[9], 32'd0);
    // R4: zero extension of a high-bit immediate
    do_ori(5'd0, 5'd1, 16'h8000);
    // R3: negative operand for signed compare
    do_rtype(6'h22, 5'd0, 5'd1, 5'd3);
    do_rtype(6'h2A, 5'd3, 5'd0, 5'd4);
    do_rtype(6'h2A, 5'd0, 5'd3, 5'd5);
    do_rtype(6'h24, 5'd3, 5'd1, 5'd6);
    do_rtype(6'h3F, 5'd3, 5'd1, 5'd7);
    // R7: unaligned store address, aligned load back
    do_sw(5'd0, 5'd3, 16'h0203);
    do_lw(5'd0, 5'd8, 16'h0200);
    check("R7 stored value returned", regs_m[8], regs_m[3]);
    // R4: negative load offset
    do_ori(5'd0, 5'd2, 16'h0400);
    do_lw(5'd2, 5'd10, 16'hFFFC);
    // R5: taken backward branch, then not taken
    do_beq(5'd4, 5'd4, 16'hFFF0);
    do_beq(5'd0, 5'd1, 16'h0010);
    // R9: jump
    do_jump(26'h0000040);

    for (int n = 0; n < 150; n++) begin
      int sel;
      logic [4:0] ra, rb, rc;
      logic [5:0] fns [5];
      fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
      sel = $urandom_range(0, 5);
      ra = 5'($urandom_range(0, 31));
      rb = 5'($urandom_range(0, 31));
      rc = 5'($urandom_range(0, 31));
      case (sel)
        0: do_rtype(fns[$urandom_range(0, 4)], ra, rb, rc);
        1: do_ori(ra, rb, 16'($urandom()));
        2: do_lw(5'd0, rb, 16'(16'h0200 + ($urandom_range(0, 63) << 2) + $urandom_range(0, 3)));
        3: do_sw(5'd0, rb, 16'(16'h0200 + ($urandom_range(0, 63) << 2) + $urandom_range(0, 3)));
        4: do_beq(ra, ($urandom_range(0, 1) == 1) ? ra : rb, 16'($urandom_range(0, 63) - 32));
        default: do_jump(26'($urandom_range(0, 1023)));
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule